// File: doc/BRIEF.md
# I2C Master Byte Controller

This block is a command-driven I2C bus master. It carries out one bus operation at a time on open-drain clock and data lines. The operations are Start, Repeated Start, Stop, transmit a byte, receive a byte, and send an acknowledge bit. Each operation is launched by a one-cycle command pulse. A byte transmit is launched by writing the data buffer. When an operation finishes, a one-cycle completion pulse is raised. The host waits for that pulse before it issues the next command. A command or buffer write that arrives while an operation is still running is dropped. A buffer write that is dropped in this way also sets a sticky collision flag.

A reloading down-counter times every half period of SCL. The counter is paused while the master has released SCL but the line still reads low, so a slave can stretch the clock. A monitor on the line inputs records whether the last bus event was a Start or a Stop. That record decides whether a new Start may be issued. The line inputs `scl_i` and `sda_i` are expected to be already synchronous to `clk`.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, the following outputs are all 0: both line drives, `busy`, `op_done`, `wcol`, `ack_stat`, `bus_s` and `bus_p`.
- R2: A `wr_buf` pulse while `busy` is 1 leaves `rd_data` unchanged and sets `wcol`. `wcol` stays 1 through later operations until a `wcol_clr` pulse clears it.
- R3: A command pulse that arrives while `busy` is 1 is ignored. The running operation keeps its normal length.
- R4: `op_done` is high for exactly one cycle when each operation completes. This applies to all six operations: Start, Repeated Start, Stop, transmit, receive and acknowledge.
- R5: A Start seen on the lines (SDA falling while SCL is high) sets `bus_s` and clears `bus_p`. A Stop seen on the lines (SDA rising while SCL is high) sets `bus_p` and clears `bus_s`. Both bits are 0 while `en` is 0.
- R6: `cmd_start` is accepted only when `bus_p` is 1, or when both `bus_s` and `bus_p` are 0. Otherwise it is ignored and `busy` stays 0.
- R7: One half SCL period lasts `divisor`+1 clocks. An operation's length is counted from the clock edge that accepts it to the edge that raises `op_done`. In half periods, the lengths are: Start 1, Repeated Start 3, Stop 2, transmit 18, receive 16, acknowledge 2.
- R8: A transmitted byte is presented MSB first. Its bits appear on SDA during SCL high periods 1 to 8, and `rd_data` shows the written byte.
- R9: During the ninth SCL high period of a transmit, SDA is released. The SDA level sampled at the end of that high period is stored in `ack_stat`: 0 means ACK, 1 means NACK.
- R10: During a receive, `sda_oe` stays 0 for all eight clocks. The bits sampled MSB first appear in `rd_data` when the operation completes.
- R11: The acknowledge command drives SDA to the level `ack_level` for one SCL clock and holds that level after completion. So `sda_oe` equals the inverse of `ack_level`.
- R12: Each clock cycle in which SCL is released but reads low adds exactly one clock to the operation.
- R13: While `en` is 0, both lines are released and every command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Module enable |
| divisor | input | 7 | Half-period reload value |
| cmd_start | input | 1 | Start condition request |
| cmd_rstart | input | 1 | Repeated Start request |
| cmd_stop | input | 1 | Stop condition request |
| cmd_rcv | input | 1 | Receive-byte request |
| cmd_ack | input | 1 | Acknowledge-bit request |
| ack_level | input | 1 | SDA level for acknowledge (0 = ACK) |
| wr_buf | input | 1 | Buffer write; starts a transmit when idle |
| wr_data | input | 8 | Byte for buffer write |
| wcol_clr | input | 1 | Clears the collision flag |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rd_data | output | 8 | Data buffer contents |
| busy | output | 1 | Operation in progress |
| op_done | output | 1 | One-cycle completion pulse |
| ack_stat | output | 1 | Acknowledge seen after transmit |
| wcol | output | 1 | Sticky write-collision flag |
| bus_s | output | 1 | Last bus event was a Start |
| bus_p | output | 1 | Last bus event was a Stop |

## Verification
A wrong phase or bit count in the sequencer is visible at the ports as a wrong completion time. An operation then ends a whole half period early or late, within a few tens of clocks, and the bench catches this by timing `op_done` to the exact cycle. A shift register that shifts in the wrong direction, or loses a bit, shows up as wrong bits on SDA. An observer captures SDA at every SCL rise, and the wrong bits appear within a single byte. A corrupted record of the bus state shows up on the next Start: that Start is either refused when it should be accepted or accepted when it should be refused, so the error appears at once.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_START,
    OP_RSTART,
    OP_STOP,
    OP_TX,
    OP_RX,
    OP_ACK
  } op_e;
endpackage

// File: rtl/i2cm_baud.sv
module i2cm_baud #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic             hold,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && !load && !hold && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= div;
    else if (run && !hold) cnt <= (cnt == '0) ? div : cnt - 1'b1;
  end

  // R12: a stretched SCL freezes the count
  assert_hold_freeze_R12: assert property (@(posedge clk) disable iff (rst)
    (run && hold && !load) |=> (cnt == $past(cnt)));
  // R7: every phase end restarts the half period from the divisor
  assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == $past(div)));
endmodule

// File: rtl/i2cm_bus_mon.sv
module i2cm_bus_mon (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic scl_i,
  input  logic sda_i,
  output logic s_q,
  output logic p_q,
  output logic bus_free
);
  logic scl_d, sda_d;
  logic start_ev, stop_ev;

  assign start_ev = scl_i && scl_d && sda_d && !sda_i;
  assign stop_ev  = scl_i && scl_d && !sda_d && sda_i;
  assign bus_free = p_q || !s_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      s_q <= 1'b0;
      p_q <= 1'b0;
    end else if (start_ev) begin
      s_q <= 1'b1;
      p_q <= 1'b0;
    end else if (stop_ev) begin
      s_q <= 1'b0;
      p_q <= 1'b1;
    end
  end

  assert_clear_off_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!s_q && !p_q));
  assert_start_seen_R5: assert property (@(posedge clk) disable iff (rst)
    (en && start_ev) |=> (s_q && !p_q));
  assert_stop_seen_R5: assert property (@(posedge clk) disable iff (rst)
    (en && stop_ev) |=> (p_q && !s_q));
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cmd_start,
  input  logic              cmd_rstart,
  input  logic              cmd_stop,
  input  logic              cmd_rcv,
  input  logic              cmd_ack,
  input  logic              ack_level,
  input  logic              wr_buf,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wcol_clr,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              bus_free,
  input  logic              tick,
  output logic              load,
  output logic              run,
  output logic              hold,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              op_done,
  output logic              ack_stat,
  output logic              wcol
);
  localparam int CW = $clog2(DATA_W + 2);

  op_e               op, nxt_op;
  logic [1:0]        ph;
  logic [CW-1:0]     bitn;
  logic [DATA_W-1:0] shreg, buf_q;
  logic              idle, accept;

  assign idle    = (op == OP_IDLE);
  assign busy    = !idle;
  assign run     = !idle;
  assign hold    = !scl_oe && !scl_i;
  assign rd_data = buf_q;

  // fixed priority among simultaneous requests; start needs a free bus
  always_comb begin
    nxt_op = OP_IDLE;
    if (en && idle) begin
      if (cmd_start)       nxt_op = bus_free ? OP_START : OP_IDLE;
      else if (cmd_rstart) nxt_op = OP_RSTART;
      else if (cmd_stop)   nxt_op = OP_STOP;
      else if (wr_buf)     nxt_op = OP_TX;
      else if (cmd_rcv)    nxt_op = OP_RX;
      else if (cmd_ack)    nxt_op = OP_ACK;
    end
  end
  assign accept = (nxt_op != OP_IDLE);
  assign load   = accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      op       <= OP_IDLE;
      ph       <= '0;
      bitn     <= '0;
      shreg    <= '0;
      buf_q    <= '0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      op_done  <= 1'b0;
      ack_stat <= 1'b0;
      wcol     <= 1'b0;
    end else begin
      op_done <= 1'b0;
      if (wcol_clr) wcol <= 1'b0;
      if (!en) begin
        op     <= OP_IDLE;
        ph     <= '0;
        scl_oe <= 1'b0;
        sda_oe <= 1'b0;
      end else if (accept) begin
        op   <= nxt_op;
        ph   <= '0;
        bitn <= '0;
        case (nxt_op)
          OP_START:  sda_oe <= 1'b1;
          OP_RSTART: sda_oe <= 1'b0;
          OP_STOP:   sda_oe <= 1'b1;
          OP_TX: begin
            buf_q  <= wr_data;
            shreg  <= wr_data;
            sda_oe <= !wr_data[DATA_W-1];
          end
          OP_RX:     sda_oe <= 1'b0;
          OP_ACK:    sda_oe <= !ack_level;
          default: ;
        endcase
      end else if (!idle) begin
        if (wr_buf) wcol <= 1'b1;
        if (tick) begin
          case (op)
            OP_START: begin
              scl_oe  <= 1'b1;
              op      <= OP_IDLE;
              op_done <= 1'b1;
            end
            OP_RSTART: begin
              ph <= ph + 1'b1;
              case (ph)
                2'd0: scl_oe <= 1'b0;
                2'd1: sda_oe <= 1'b1;
                default: begin
                  scl_oe  <= 1'b1;
                  op      <= OP_IDLE;
                  op_done <= 1'b1;
                end
              endcase
            end
            OP_STOP: begin
              if (ph == 2'd0) begin
                scl_oe <= 1'b0;
                ph     <= 2'd1;
              end else begin
                sda_oe  <= 1'b0;
                op      <= OP_IDLE;
                op_done <= 1'b1;
              end
            end
            OP_TX: begin
              if (ph == 2'd0) begin
                scl_oe <= 1'b0;
                ph     <= 2'd1;
              end else begin
                scl_oe <= 1'b1;
                ph     <= 2'd0;
                if (bitn == CW'(DATA_W)) begin
                  ack_stat <= sda_i;
                  op       <= OP_IDLE;
                  op_done  <= 1'b1;
                end else begin
                  bitn   <= bitn + 1'b1;
                  shreg  <= shreg << 1;
                  sda_oe <= (bitn == CW'(DATA_W - 1)) ? 1'b0 : !shreg[DATA_W-2];
                end
              end
            end
            OP_RX: begin
              if (ph == 2'd0) begin
                scl_oe <= 1'b0;
                ph     <= 2'd1;
              end else begin
                scl_oe <= 1'b1;
                ph     <= 2'd0;
                shreg  <= {shreg[DATA_W-2:0], sda_i};
                if (bitn == CW'(DATA_W - 1)) begin
                  buf_q   <= {shreg[DATA_W-2:0], sda_i};
                  op      <= OP_IDLE;
                  op_done <= 1'b1;
                end else begin
                  bitn <= bitn + 1'b1;
                end
              end
            end
            OP_ACK: begin
              if (ph == 2'd0) begin
                scl_oe <= 1'b0;
                ph     <= 2'd1;
              end else begin
                scl_oe  <= 1'b1;
                op      <= OP_IDLE;
                op_done <= 1'b1;
              end
            end
            default: op <= OP_IDLE;
          endcase
        end
      end
    end
  end

  assert_wcol_set_R2: assert property (@(posedge clk) disable iff (rst)
    (en && busy && wr_buf) |=> wcol);
  assert_buf_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_buf && op != OP_RX) |=> $stable(buf_q));
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (rst)
    op_done |-> !busy);
  assert_rx_released_R10: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RX) |-> !sda_oe);
  assert_off_released_R13: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!scl_oe && !sda_oe && !busy));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              cmd_start,
  input  logic              cmd_rstart,
  input  logic              cmd_stop,
  input  logic              cmd_rcv,
  input  logic              cmd_ack,
  input  logic              ack_level,
  input  logic              wr_buf,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wcol_clr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              op_done,
  output logic              ack_stat,
  output logic              wcol,
  output logic              bus_s,
  output logic              bus_p
);
  logic bus_free, tick, load, run, hold;

  i2cm_bus_mon u_mon (
    .clk(clk), .rst(rst), .en(en), .scl_i(scl_i), .sda_i(sda_i),
    .s_q(bus_s), .p_q(bus_p), .bus_free(bus_free)
  );

  i2cm_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .run(run), .load(load), .hold(hold),
    .div(divisor), .tick(tick)
  );

  i2cm_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .en(en),
    .cmd_start(cmd_start), .cmd_rstart(cmd_rstart), .cmd_stop(cmd_stop),
    .cmd_rcv(cmd_rcv), .cmd_ack(cmd_ack), .ack_level(ack_level),
    .wr_buf(wr_buf), .wr_data(wr_data), .wcol_clr(wcol_clr),
    .scl_i(scl_i), .sda_i(sda_i), .bus_free(bus_free), .tick(tick),
    .load(load), .run(run), .hold(hold),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rd_data(rd_data),
    .busy(busy), .op_done(op_done), .ack_stat(ack_stat), .wcol(wcol)
  );
endmodule

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst, en, cmd_start, cmd_rstart, cmd_stop, cmd_rcv, cmd_ack;
  logic       ack_level, wr_buf, wcol_clr;
  logic [6:0] divisor;
  logic [7:0] wr_data, rd_data;
  logic       scl_oe, sda_oe, busy, op_done, ack_stat, wcol, bus_s, bus_p;
  logic       scl_line, sda_line, slave_low;

  // bus and slave model
  logic [1:0] mode;
  logic       want_ack, mon_clr, st_load;
  logic [7:0] rx_byte, st_val, st_cnt;
  logic [3:0] falls;
  logic [8:0] cap;
  logic       prev_scl;
  int         rx_bad;

  assign scl_line = !(scl_oe || (st_cnt != 8'd0));
  assign sda_line = !(sda_oe || slave_low);

  always_comb begin
    slave_low = 1'b0;
    if (mode == 2'd1 && want_ack && falls == 4'd8) slave_low = 1'b1;
    else if (mode == 2'd2 && falls < 4'd8) slave_low = !rx_byte[3'(4'd7 - falls)];
  end

  always @(posedge clk) begin
    prev_scl <= scl_line;
    if (mon_clr) begin
      falls  <= '0;
      cap    <= '0;
      rx_bad <= 0;
    end else begin
      if (prev_scl && !scl_line) falls <= falls + 1'b1;
      if (!prev_scl && scl_line) cap <= {cap[7:0], sda_line};
      if (mode == 2'd2 && busy && sda_oe) rx_bad <= rx_bad + 1;
    end
    if (st_load) st_cnt <= st_val;
    else if (!scl_oe && st_cnt != 8'd0) st_cnt <= st_cnt - 1'b1;
  end

  i2c_byte_master u0 (
    .clk(clk), .rst(rst), .en(en), .divisor(divisor),
    .cmd_start(cmd_start), .cmd_rstart(cmd_rstart), .cmd_stop(cmd_stop),
    .cmd_rcv(cmd_rcv), .cmd_ack(cmd_ack), .ack_level(ack_level),
    .wr_buf(wr_buf), .wr_data(wr_data), .wcol_clr(wcol_clr),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .rd_data(rd_data), .busy(busy), .op_done(op_done), .ack_stat(ack_stat),
    .wcol(wcol), .bus_s(bus_s), .bus_p(bus_p)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // transmit vectors: {pad, divisor[6:0], byte, 3'b0, nack, stretch[3:0]}
  localparam logic [23:0] VEC [5] = '{
    24'h01A500, 24'h033C15, 24'h06FF10, 24'h020003, 24'h00C310
  };

  // code: 0 start, 1 rstart, 2 stop, 3 transmit, 4 receive, 5 acknowledge
  task automatic run_op(input int code, input int exp_cyc, input string req, input int inj);
    int k;
    @(negedge clk);
    case (code)
      0: cmd_start = 1'b1;
      1: cmd_rstart = 1'b1;
      2: cmd_stop = 1'b1;
      3: wr_buf = 1'b1;
      4: cmd_rcv = 1'b1;
      default: cmd_ack = 1'b1;
    endcase
    @(posedge clk); #1;
    {cmd_start, cmd_rstart, cmd_stop, wr_buf, cmd_rcv, cmd_ack} = '0;
    k = 0;
    while (!op_done && k < 4000) begin
      @(posedge clk); #1;
      k++;
      wr_buf = 1'b0; cmd_stop = 1'b0;
      if (k == inj) begin
        wr_buf = 1'b1; wr_data = 8'h11; cmd_stop = 1'b1;
      end
    end
    wr_buf = 1'b0; cmd_stop = 1'b0;
    chk(req, k, exp_cyc);
    @(posedge clk); #1;
    chk("R4 done pulse width", op_done, 0);
  endtask

  task automatic mon_reset(input logic [7:0] stretch);
    @(negedge clk);
    mon_clr = 1'b1; st_load = 1'b1; st_val = stretch;
    @(negedge clk);
    mon_clr = 1'b0; st_load = 1'b0;
  endtask

  initial begin
    rst = 1'b1; en = 1'b1; divisor = 7'd3;
    {cmd_start, cmd_rstart, cmd_stop, wr_buf, cmd_rcv, cmd_ack} = '0;
    ack_level = 1'b0; wcol_clr = 1'b0; wr_data = 8'h00;
    mode = 2'd0; want_ack = 1'b0; rx_byte = 8'h00;
    mon_clr = 1'b1; st_load = 1'b1; st_val = 8'd0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; mon_clr = 1'b0; st_load = 1'b0;
    // R1 reset state
    chk("R1 outputs after reset",
        {scl_oe, sda_oe, busy, op_done, wcol, ack_stat, bus_s, bus_p}, 0);

    // Start on an idle bus: one half period
    run_op(0, 4, "R7 start length", -1);
    chk("R5 S after start", {bus_s, bus_p}, 2'b10);
    chk("R4 scl held low after start", scl_oe, 1);

    // R6: start refused while S is set
    @(negedge clk); cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 start refused when bus owned", {busy, scl_oe}, 2'b01);

    // transmit vectors
    mode = 2'd1;
    for (int i = 0; i < 5; i++) begin
      logic [23:0] v;
      v = VEC[i];
      divisor = v[22:16];
      want_ack = !v[4];
      wr_data = v[15:8];
      mon_reset({4'd0, v[3:0]});
      run_op(3, 18 * (int'(v[22:16]) + 1) + int'(v[3:0]), "R7 R12 transmit length", -1);
      chk("R8 bits on SDA MSB first", cap[8:1], v[15:8]);
      chk("R9 ninth-bit SDA level", cap[0], v[4]);
      chk("R9 ack status", ack_stat, v[4]);
      chk("R8 buffer holds written byte", rd_data, v[15:8]);
    end

    // collision and ignored stop during a transmit
    divisor = 7'd3; want_ack = 1'b1; wr_data = 8'h5A;
    mon_reset(8'd0);
    run_op(3, 72, "R3 length unchanged by stray stop", 10);
    chk("R2 buffer untouched by late write", rd_data, 8'h5A);
    chk("R2 collision flag set", wcol, 1);
    chk("R3 stop ignored, SCL still held", scl_oe, 1);

    // receive
    mode = 2'd2; rx_byte = 8'hA6;
    mon_reset(8'd0);
    run_op(4, 64, "R7 receive length", -1);
    chk("R10 received byte", rd_data, 8'hA6);
    chk("R10 SDA released while receiving", rx_bad, 0);
    chk("R2 collision flag sticky", wcol, 1);
    @(negedge clk); wcol_clr = 1'b1;
    @(negedge clk); wcol_clr = 1'b0;
    chk("R2 collision flag cleared", wcol, 0);

    // acknowledge both levels
    mode = 2'd0;
    ack_level = 1'b1;
    run_op(5, 8, "R7 ack length", -1);
    chk("R11 NACK leaves SDA released", sda_oe, 0);
    ack_level = 1'b0;
    run_op(5, 8, "R7 ack length", -1);
    chk("R11 ACK drives SDA low", sda_oe, 1);

    // repeated start, stop, fresh start
    run_op(1, 12, "R7 repeated start length", -1);
    chk("R5 S after repeated start", {bus_s, bus_p}, 2'b10);
    run_op(2, 8, "R7 stop length", -1);
    chk("R5 P after stop", {bus_p, bus_s}, 2'b10);
    chk("R4 lines released after stop", {scl_oe, sda_oe}, 2'b00);
    run_op(0, 4, "R6 start accepted after stop", -1);
    chk("R5 S after new start", {bus_s, bus_p}, 2'b10);

    // disable
    @(negedge clk); en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R13 lines released when off", {scl_oe, sda_oe}, 2'b00);
    chk("R5 S and P cleared when off", {bus_s, bus_p}, 2'b00);
    cmd_start = 1'b1; wr_buf = 1'b1;
    @(negedge clk); cmd_start = 1'b0; wr_buf = 1'b0;
    @(negedge clk);
    chk("R13 commands ignored when off", {busy, scl_oe, sda_oe, wcol}, 4'b0000);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule